// File: doc/BRIEF.md
# Multi-Waveform Digital Test Pattern Generator

This block produces digital stimulus words for a DAC during built-in self-test of analog circuitry. One shared state register works as an up counter, a down counter, a bouncing triangle counter, a maximal-length LFSR, or a half-period timer, depending on the selected waveform. A magnitude register supplies DC levels and steps. A thermometer-coded sweep shift register stretches the half-period of a square wave after every full period, which gives frequency sweeps at constant or growing amplitude. Any waveform can be sent out bit-reversed, which turns smooth patterns into noise-like content.

In normal operation the DAC receives the system data word. While the BIST enable is high, the generator word replaces it. Each time the enable goes low, the generator returns to its start state. The waveform code must therefore be changed only while the enable is low. The output mux is combinational. The generator state advances on every rising clock edge that sees the enable high.

Top module: `stim_wave_gen`

## Requirements
- R1: While `bist_en` is 0, `dac_data` equals `sys_data` in the same cycle, and the generator state returns to its start state at the next rising edge.
- R2: With `mode` held and `bist_en` raised, the word seen before the first rising edge with `bist_en`=1 is sample 0, and each such edge advances one sample. `mode[3]` enables reversal; `mode[2:0]` selects the waveform: 0 up ramp, 1 down ramp, 2 triangle, 3 LFSR, 4 DC level, 5 step, 6 sweep at constant amplitude, 7 sweep at growing amplitude.
- R3: Up ramp: sample k is k mod 2^N. Down ramp: sample k is (2^N - k) mod 2^N. N is the DAC width.
- R4: Triangle: the samples run 0, 1, …, 2^N-1, 2^N-2, …, 0, 1, … with a period of 2(2^N-1). The word never repeats on consecutive samples.
- R5: LFSR: sample 0 is 1. No sample is 0. Samples 0 to 2^N-2 are all distinct, and sample 2^N-1 equals sample 0.
- R6: A write through `mag_we`/`mag_wdata` loads the magnitude register at the rising edge. In DC mode the word equals the magnitude register, so a write becomes visible one edge after it is presented.
- R7: Step: sample 0 is 0, and every later sample equals the magnitude register.
- R8: Constant-amplitude sweep: the sweep unit has S bits. It produces square-wave periods with half-period lengths L = 1, 2, …, S+1, in that order, and then repeats. Each period holds the magnitude value for L samples and then 0 for L samples.
- R9: Growing-amplitude sweep: the timing is the same as in R8, but the high level in a period with half-length L is the magnitude shifted right by S+1-L bits.
- R10: When `mode[3]` is 1, bit i of the generated word appears on bit N-1-i of `dac_data`.
- R11: A synchronous active-high `rst` clears the magnitude register to 0 and the generator state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Selects test data toward the DAC and lets the generator run |
| mode | input | 4 | Bit 3 reverses the word; bits 2:0 select the waveform |
| mag_we | input | 1 | Magnitude register write strobe |
| mag_wdata | input | DATA_W | Magnitude register write data |
| sys_data | input | DATA_W | Normal system data word |
| dac_data | output | DATA_W | Word toward the DAC |

## Verification
The DAC word is combinational from the generator state. Sample 0 is therefore checked one time step after the enable rises, before any rising edge. Each later sample is checked at the falling edge after the rising edge that produced it. A magnitude write is presented before a rising edge, and its effect is checked at the following falling edge, while the word before that edge is confirmed to be unchanged. The system-data path and the restart are checked in the same cycle that the enable falls, and again one edge later when the enable is raised.

// File: rtl/swg_pkg.sv
package swg_pkg;

    typedef enum logic [2:0] {
        WV_RAMP_UP    = 3'd0,
        WV_RAMP_DN    = 3'd1,
        WV_TRI        = 3'd2,
        WV_NOISE      = 3'd3,
        WV_LEVEL      = 3'd4,
        WV_STEP       = 3'd5,
        WV_SWEEP_FLAT = 3'd6,
        WV_SWEEP_GROW = 3'd7
    } wave_e;

    typedef struct packed {
        logic  reverse;
        wave_e wave;
    } mode_t;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    // Feedback masks for a left-shifting Fibonacci LFSR, maximal length.
    function automatic logic [23:0] noise_taps(input int unsigned w);
        case (w)
            4:       return 24'h00000C;
            5:       return 24'h000014;
            6:       return 24'h000030;
            7:       return 24'h000060;
            8:       return 24'h0000B8;
            9:       return 24'h000110;
            10:      return 24'h000240;
            11:      return 24'h000500;
            12:      return 24'h000829;
            13:      return 24'h00100D;
            14:      return 24'h002015;
            15:      return 24'h006000;
            16:      return 24'h00D008;
            17:      return 24'h012000;
            18:      return 24'h020400;
            19:      return 24'h040023;
            20:      return 24'h090000;
            21:      return 24'h140000;
            22:      return 24'h300000;
            23:      return 24'h420000;
            default: return 24'hE10000;
        endcase
    endfunction

    function automatic logic is_sweep(input wave_e w);
        return (w == WV_SWEEP_FLAT) || (w == WV_SWEEP_GROW);
    endfunction

endpackage

// File: rtl/swg_count_core.sv
module swg_count_core
    import swg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ONES_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  wave_e             wave,
    input  logic [ONES_W-1:0] sweep_ones,
    output logic [DATA_W-1:0] cnt,
    output logic              hp_done
);
    localparam logic [DATA_W-1:0] TAPS   = DATA_W'(noise_taps(DATA_W));
    localparam logic [DATA_W-1:0] ALL1   = '1;
    localparam logic [DATA_W-1:0] SEED   = DATA_W'(1);

    dir_e              dir;
    logic [DATA_W-1:0] cnt_nxt;
    dir_e              dir_nxt;
    logic              fb;
    logic              past_ok;

    assign fb      = ^(cnt & TAPS);
    assign hp_done = is_sweep(wave) && (cnt == DATA_W'(sweep_ones));

    always_comb begin
        cnt_nxt = cnt;
        dir_nxt = dir;
        if (!run) begin
            cnt_nxt = (wave == WV_NOISE) ? SEED : '0;
            dir_nxt = DIR_UP;
        end else begin
            case (wave)
                WV_RAMP_UP: cnt_nxt = cnt + 1'b1;
                WV_RAMP_DN: cnt_nxt = cnt - 1'b1;
                WV_TRI: begin
                    if (dir == DIR_UP) begin
                        if (cnt == ALL1) begin
                            cnt_nxt = cnt - 1'b1;
                            dir_nxt = DIR_DN;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end else begin
                        if (cnt == '0) begin
                            cnt_nxt = cnt + 1'b1;
                            dir_nxt = DIR_UP;
                        end else begin
                            cnt_nxt = cnt - 1'b1;
                        end
                    end
                end
                WV_NOISE:      cnt_nxt = {cnt[DATA_W-2:0], fb};
                WV_SWEEP_FLAT,
                WV_SWEEP_GROW: cnt_nxt = hp_done ? '0 : cnt + 1'b1;
                default:       cnt_nxt = cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            dir     <= DIR_UP;
            past_ok <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            dir     <= dir_nxt;
            past_ok <= 1'b1;
        end
    end

    // R4: the triangle never holds a value for two samples
    assert_tri_no_repeat_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && run && $past(run) && wave == WV_TRI && $past(wave) == WV_TRI)
        |-> (cnt != $past(cnt)));

    // R5: the LFSR never reaches the all-zero lock-up state
    assert_noise_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(run) && $past(wave) == WV_NOISE && $past(cnt) != '0)
        |-> (cnt != '0));

    // R3: the up ramp moves by exactly one each running cycle
    assert_ramp_step_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(run) && $past(wave) == WV_RAMP_UP && wave == WV_RAMP_UP)
        |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/swg_sweep_ctl.sv
module swg_sweep_ctl #(
    parameter int SWEEP_W = 4,
    parameter int ONES_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              hp_done,
    output logic [ONES_W-1:0] ones,
    output logic              tog
);
    logic [SWEEP_W-1:0] therm;
    logic [SWEEP_W:0]   grow;

    assign grow = {therm, 1'b1};

    always_comb begin
        ones = '0;
        for (int i = 0; i < SWEEP_W; i++) begin
            ones = ones + ONES_W'(therm[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            therm <= '0;
            tog   <= 1'b1;
        end else if (hp_done) begin
            tog <= ~tog;
            if (!tog) begin
                therm <= (&therm) ? '0 : grow[SWEEP_W-1:0];
            end
        end
    end

    // R8: the sweep register stays a thermometer code
    assert_sweep_thermo_R8: assert property (@(posedge clk) disable iff (rst)
        (therm & (therm + 1'b1)) == '0);

    // R8: the half-period length only changes at the end of a low half
    assert_sweep_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !(hp_done && !tog)) |=> (!run || $stable(therm)));

endmodule

// File: rtl/swg_word_sel.sv
module swg_word_sel
    import swg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SWEEP_W = 4,
    parameter int ONES_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  wave_e             wave,
    input  logic              mag_we,
    input  logic [DATA_W-1:0] mag_wdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              tog,
    input  logic [ONES_W-1:0] ones,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] mag;
    logic              stepped;
    logic [ONES_W-1:0] shamt;
    logic              past_ok;

    assign shamt = ONES_W'(SWEEP_W) - ones;

    always_ff @(posedge clk) begin
        if (rst) begin
            mag     <= '0;
            stepped <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            stepped <= run;
            if (mag_we) begin
                mag <= mag_wdata;
            end
        end
    end

    always_comb begin
        case (wave)
            WV_LEVEL:      word = mag;
            WV_STEP:       word = stepped ? mag : '0;
            WV_SWEEP_FLAT: word = tog ? mag : '0;
            WV_SWEEP_GROW: word = tog ? (mag >> shamt) : '0;
            default:       word = cnt;
        endcase
    end

    // R6: a write lands in the magnitude register at the next edge
    assert_mag_load_R6: assert property (@(posedge clk) disable iff (rst)
        mag_we |=> (mag == $past(mag_wdata)));

    // R7: once stepped, the level stays up while running
    assert_step_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && stepped && run) |=> stepped);

endmodule

// File: rtl/swg_dac_mux.sv
module swg_dac_mux #(
    parameter int DATA_W = 8
) (
    input  logic              bist_en,
    input  logic              reverse,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] sys_data,
    output logic [DATA_W-1:0] dac_data
);
    logic [DATA_W-1:0] flipped;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign flipped[i] = word[DATA_W-1-i];
    end

    always_comb begin
        if (!bist_en) begin
            dac_data = sys_data;
        end else if (reverse) begin
            dac_data = flipped;
        end else begin
            dac_data = word;
        end
    end

    // R10: reversal mirrors the end bits of the word
    always_comb begin
        if (bist_en && reverse) begin
            assert_rev_ends_R10: assert ((dac_data[0] == word[DATA_W-1]) &&
                                         (dac_data[DATA_W-1] == word[0]));
        end
    end

endmodule

// File: rtl/stim_wave_gen.sv
module stim_wave_gen
    import swg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SWEEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_en,
    input  logic [3:0]        mode,
    input  logic              mag_we,
    input  logic [DATA_W-1:0] mag_wdata,
    input  logic [DATA_W-1:0] sys_data,
    output logic [DATA_W-1:0] dac_data
);
    localparam int ONES_W = $clog2(SWEEP_W + 1);

    mode_t             sel;
    logic [DATA_W-1:0] cnt;
    logic              hp_done;
    logic [ONES_W-1:0] ones;
    logic              tog;
    logic [DATA_W-1:0] word;

    assign sel = mode_t'(mode);

    swg_count_core #(.DATA_W(DATA_W), .ONES_W(ONES_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .run        (bist_en),
        .wave       (sel.wave),
        .sweep_ones (ones),
        .cnt        (cnt),
        .hp_done    (hp_done)
    );

    swg_sweep_ctl #(.SWEEP_W(SWEEP_W), .ONES_W(ONES_W)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .run     (bist_en),
        .hp_done (hp_done),
        .ones    (ones),
        .tog     (tog)
    );

    swg_word_sel #(.DATA_W(DATA_W), .SWEEP_W(SWEEP_W), .ONES_W(ONES_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .run       (bist_en),
        .wave      (sel.wave),
        .mag_we    (mag_we),
        .mag_wdata (mag_wdata),
        .cnt       (cnt),
        .tog       (tog),
        .ones      (ones),
        .word      (word)
    );

    swg_dac_mux #(.DATA_W(DATA_W)) u_mux (
        .bist_en  (bist_en),
        .reverse  (sel.reverse),
        .word     (word),
        .sys_data (sys_data),
        .dac_data (dac_data)
    );

    // R1: a stopped generator hands the DAC the system word
    assert_sys_pass_R1: assert property (@(posedge clk) disable iff (rst)
        !bist_en |-> (dac_data == sys_data));

endmodule

// File: tb/stim_wave_gen_bench.sv
`timescale 1ns/1ps
module stim_wave_gen_bench;
    localparam int DW  = 8;
    localparam int SW  = 3;
    localparam int MAG = 8'hD6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bist_en = 1'b0;
    logic [3:0]    mode = '0;
    logic          mag_we = 1'b0;
    logic [DW-1:0] mag_wdata = '0;
    logic [DW-1:0] sys_data = '0;
    logic [DW-1:0] dac_data;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stim_wave_gen #(.DATA_W(DW), .SWEEP_W(SW)) u_stim_wave_gen (
        .clk(clk), .rst(rst), .bist_en(bist_en), .mode(mode),
        .mag_we(mag_we), .mag_wdata(mag_wdata),
        .sys_data(sys_data), .dac_data(dac_data)
    );

    function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
        return r;
    endfunction

    function automatic int sweep_exp(input int k, input bit grow, input int mag);
        int p;
        p = k % ((SW + 1) * (SW + 2));
        for (int l = 1; l <= SW + 1; l++) begin
            if (p < 2 * l) begin
                if (p >= l) return 0;
                return grow ? (mag >> (SW + 1 - l)) : mag;
            end
            p = p - 2 * l;
        end
        return 0;
    endfunction

    function automatic int wave_exp(input int w, input int k, input int mag);
        int m1, p;
        m1 = (1 << DW) - 1;
        case (w)
            0: return k % (1 << DW);
            1: return ((1 << DW) - (k % (1 << DW))) % (1 << DW);
            2: begin
                p = k % (2 * m1);
                return (p <= m1) ? p : 2 * m1 - p;
            end
            4: return mag;
            5: return (k == 0) ? 0 : mag;
            6: return sweep_exp(k, 1'b0, mag);
            default: return sweep_exp(k, 1'b1, mag);
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: dac_data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_mag(input logic [DW-1:0] v);
        @(negedge clk);
        mag_we = 1'b1;
        mag_wdata = v;
        @(negedge clk);
        mag_we = 1'b0;
    endtask

    // Select a mode with the enable low for one edge, then raise it; returns at sample 0.
    task automatic start_mode(input int m);
        @(negedge clk);
        bist_en = 1'b0;
        mode = 4'(m);
        @(negedge clk);
        bist_en = 1'b1;
        #1;
    endtask

    task automatic next_sample;
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        sys_data = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R11 reset output is system data", dac_data, 8'h5A);
        rst = 1'b0;
        mode = 4'd4;
        @(negedge clk);
        bist_en = 1'b1;
        #1;
        chk("R11 magnitude cleared by reset", dac_data, 8'h00);
        bist_en = 1'b0;

        // R1: system data passes while stopped
        for (int v = 0; v < 256; v += 17) begin
            sys_data = 8'(v);
            #1;
            chk("R1 system pass-through", dac_data, 8'(v));
        end
        sys_data = 8'h5A;

        write_mag(8'(MAG));

        // R2..R10: every mode code, plain and reversed
        for (int m = 0; m < 16; m++) begin
            int w;
            bit rv;
            w  = m % 8;
            rv = (m >= 8);
            start_mode(m);
            if (w == 3) begin
                bit [255:0] seen;
                logic [DW-1:0] s, first;
                seen = '0;
                for (int k = 0; k < 256; k++) begin
                    if (k > 0) next_sample();
                    s = rv ? rev(dac_data) : dac_data;
                    if (k == 0) begin
                        first = s;
                        chk(rv ? "R10 R5 LFSR seed" : "R5 LFSR seed", s, 8'h01);
                    end else if (k == 255) begin
                        chk("R5 LFSR period closes", s, first);
                    end else begin
                        chk("R5 LFSR nonzero", (s == 0) ? 8'h00 : 8'h01, 8'h01);
                        chk("R5 LFSR unique", seen[s] ? 8'h01 : 8'h00, 8'h00);
                    end
                    seen[s] = 1'b1;
                end
            end else begin
                for (int k = 0; k < 600; k++) begin
                    logic [DW-1:0] e;
                    if (k > 0) next_sample();
                    e = 8'(wave_exp(w, k, MAG));
                    if (rv) e = rev(e);
                    case (w)
                        0, 1:    chk(rv ? "R10 R3 ramp reversed" : "R3 ramp", dac_data, e);
                        2:       chk(rv ? "R10 R4 triangle reversed" : "R4 triangle", dac_data, e);
                        4:       chk(rv ? "R10 R6 level reversed" : "R6 level", dac_data, e);
                        5:       chk(rv ? "R10 R7 step reversed" : "R7 step", dac_data, e);
                        6:       chk(rv ? "R10 R8 sweep reversed" : "R8 sweep", dac_data, e);
                        default: chk(rv ? "R10 R9 sweep reversed" : "R9 growing sweep", dac_data, e);
                    endcase
                end
            end
        end

        // R6: a write while in DC mode shows one edge later
        start_mode(4);
        chk("R6 level before write", dac_data, 8'(MAG));
        mag_we = 1'b1;
        mag_wdata = 8'h3A;
        #0.5;
        chk("R6 level unchanged before edge", dac_data, 8'(MAG));
        next_sample();
        mag_we = 1'b0;
        chk("R6 level after write", dac_data, 8'h3A);
        @(negedge clk);
        bist_en = 1'b0;
        mode = 4'd12;
        @(negedge clk);
        bist_en = 1'b1;
        #1;
        chk("R10 reversed level", dac_data, 8'h5C);

        // R1: stopping restarts the generator
        start_mode(0);
        for (int k = 1; k < 5; k++) next_sample();
        chk("R2 ramp before stop", dac_data, 8'h04);
        @(negedge clk);
        bist_en = 1'b0;
        sys_data = 8'hA7;
        #1;
        chk("R1 stopped output", dac_data, 8'hA7);
        @(negedge clk);
        bist_en = 1'b1;
        #1;
        chk("R1 restart at sample 0", dac_data, 8'h00);
        next_sample();
        chk("R2 first edge advances", dac_data, 8'h01);

        finish_run();
    end

endmodule